// File: doc/BRIEF.md
# Timer Master Trigger Output Selector

This block produces the synchronisation pulse that a master timer sends to its slave timers. A 3-bit selection code picks one of six timer events. When the picked event occurs, a registered one-cycle pulse appears on `trgo` on the next clock. Four of the events arrive as single-cycle strobes from the timer core: counter reset, counter start, update, and the channel 0 capture/compare pulse. The other two are level reference signals from the compare logic of channels 0 and 1. For these two, the qualifying event is a rising edge, which the block detects itself.

Two selection codes are reserved and never produce a pulse. The edge history of both reference signals is tracked on every cycle, whatever code is selected. Because of this, switching the code onto a reference that is already high does not produce a pulse.

Top module: `tmr_sync_trigger_out`

## Requirements
- R1: With `sel` = 3'b000, `trgo` is high in the cycle after `evt_cnt_reset` is sampled high.
- R2: With `sel` = 3'b001, `trgo` is high in the cycle after `evt_cnt_start` is sampled high.
- R3: With `sel` = 3'b010, `trgo` is high in the cycle after `evt_update` is sampled high.
- R4: With `sel` = 3'b011, `trgo` is high in the cycle after `evt_ch0_cc` is sampled high.
- R5: With `sel` = 3'b100, `trgo` is high for exactly one cycle after each clock edge at which `cmp_ref0` is sampled high and was sampled low at the previous edge. A level that stays high gives no further pulses.
- R6: With `sel` = 3'b101, the same rule as R5 applies to `cmp_ref1`.
- R7: With `sel` = 3'b110 or 3'b111, `trgo` stays low whatever the event inputs do.
- R8: In the cycle after an edge where the selected source shows no event, `trgo` is low. Activity on sources that are not selected has no effect on `trgo`.
- R9: A change of `sel` applies from the clock edge at which the new value is sampled. A change of `sel` never creates a pulse by itself. In particular, selecting a reference that has already been high for a cycle or more gives no pulse.
- R10: While `rst_n` is low, `trgo` is low and both reference histories read as low. After release, a reference that is high at the first edge counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Trigger source selection code |
| evt_cnt_reset | input | 1 | Counter reset event strobe |
| evt_cnt_start | input | 1 | Counter start event strobe |
| evt_update | input | 1 | Update event strobe (already filtered by the timer core) |
| evt_ch0_cc | input | 1 | Channel 0 capture/compare pulse |
| cmp_ref0 | input | 1 | Channel 0 compare reference level |
| cmp_ref1 | input | 1 | Channel 1 compare reference level |
| trgo | output | 1 | Registered trigger output pulse |

## Verification
The assertions check on every cycle that each strobe-driven code forwards its event to `trgo` one cycle later, that a fresh reference edge in codes 100 and 101 is forwarded, and that the reserved codes stay silent. Several behaviours are visible only in the bench scenarios, which compare against a cycle model: that unselected sources are ignored, that a held reference level pulses only once, that switching onto an already-high reference stays quiet, and that a reference held high through reset fires once after release.

// File: rtl/tmr_trgo_pkg.sv
package tmr_trgo_pkg;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_CODE = 1 << SEL_W;
  localparam int unsigned NUM_REF  = 2;
  localparam int unsigned NUM_LIVE = 6;

  typedef enum logic [SEL_W-1:0] {
    TRG_CNT_RESET = 3'b000,
    TRG_CNT_START = 3'b001,
    TRG_UPDATE    = 3'b010,
    TRG_CH0_CC    = 3'b011,
    TRG_REF0_RISE = 3'b100,
    TRG_REF1_RISE = 3'b101,
    TRG_RSVD_A    = 3'b110,
    TRG_RSVD_B    = 3'b111
  } trg_src_e;
endpackage

// File: rtl/tmr_ref_edge.sv
module tmr_ref_edge #(
  parameter int unsigned NREF = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREF-1:0] ref_i,
  output logic [NREF-1:0] rise_o
);
  for (genvar g = 0; g < NREF; g++) begin : g_ref
    logic hist_q;
    logic hist_d;
    logic hist_en;

    always_comb begin
      hist_d  = ref_i[g];
      hist_en = (hist_d != hist_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hist_q <= 1'b0;
      else if (hist_en) hist_q <= hist_d;
    end

    assign rise_o[g] = ref_i[g] & ~hist_q;
  end
endmodule

// File: rtl/tmr_trg_mux.sv
module tmr_trg_mux
  import tmr_trgo_pkg::*;
(
  input  logic [SEL_W-1:0]   sel,
  input  logic               ev_rst,
  input  logic               ev_start,
  input  logic               ev_upd,
  input  logic               ev_cc0,
  input  logic [NUM_REF-1:0] ref_rise,
  output logic               pick
);
  logic [NUM_CODE-1:0] src_vec;

  always_comb begin
    src_vec[TRG_CNT_RESET] = ev_rst;
    src_vec[TRG_CNT_START] = ev_start;
    src_vec[TRG_UPDATE]    = ev_upd;
    src_vec[TRG_CH0_CC]    = ev_cc0;
    src_vec[TRG_REF0_RISE] = ref_rise[0];
    src_vec[TRG_REF1_RISE] = ref_rise[1];
  end

  for (genvar g = NUM_LIVE; g < NUM_CODE; g++) begin : g_rsvd
    assign src_vec[g] = 1'b0;
  end

  assign pick = src_vec[sel];
endmodule

// File: rtl/tmr_sync_trigger_out.sv
module tmr_sync_trigger_out
  import tmr_trgo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       evt_cnt_reset,
  input  logic       evt_cnt_start,
  input  logic       evt_update,
  input  logic       evt_ch0_cc,
  input  logic       cmp_ref0,
  input  logic       cmp_ref1,
  output logic       trgo
);
  logic [NUM_REF-1:0] ref_lvl;
  logic [NUM_REF-1:0] ref_rise;
  logic               pick;
  logic               trgo_q;
  logic               trgo_d;
  logic               trgo_en;

  assign ref_lvl = {cmp_ref1, cmp_ref0};

  tmr_ref_edge #(.NREF(NUM_REF)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_i  (ref_lvl),
    .rise_o (ref_rise)
  );

  tmr_trg_mux u_mux (
    .sel      (sel),
    .ev_rst   (evt_cnt_reset),
    .ev_start (evt_cnt_start),
    .ev_upd   (evt_update),
    .ev_cc0   (evt_ch0_cc),
    .ref_rise (ref_rise),
    .pick     (pick)
  );

  always_comb begin
    trgo_d  = pick;
    trgo_en = trgo_d | trgo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trgo_q <= 1'b0;
    else if (trgo_en) trgo_q <= trgo_d;
  end

  assign trgo = trgo_q;
endmodule

// File: rtl/tmr_sync_trigger_out_chk.sv
module tmr_sync_trigger_out_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] sel,
  input logic       evt_cnt_reset,
  input logic       evt_cnt_start,
  input logic       evt_update,
  input logic       evt_ch0_cc,
  input logic       cmp_ref0,
  input logic       cmp_ref1,
  input logic       trgo
);
  AST_RESET_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'b000 && evt_cnt_reset) |=> trgo); // R1
  AST_START_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'b001 && evt_cnt_start) |=> trgo); // R2
  AST_UPDATE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'b010 && evt_update) |=> trgo); // R3
  AST_CC0_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'b011 && evt_ch0_cc) |=> trgo); // R4
  AST_REF0_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'b100 && cmp_ref0 && !$past(cmp_ref0)) |=> trgo); // R5
  AST_REF1_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'b101 && cmp_ref1 && !$past(cmp_ref1)) |=> trgo); // R6
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[2:1] == 2'b11) |=> !trgo); // R7
  AST_RESET_LOW: assert property (@(negedge clk)
    !rst_n |-> !trgo); // R10
endmodule

bind tmr_sync_trigger_out tmr_sync_trigger_out_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sel           (sel),
  .evt_cnt_reset (evt_cnt_reset),
  .evt_cnt_start (evt_cnt_start),
  .evt_update    (evt_update),
  .evt_ch0_cc    (evt_ch0_cc),
  .cmp_ref0      (cmp_ref0),
  .cmp_ref1      (cmp_ref1),
  .trgo          (trgo)
);

// File: tb/tmr_sync_trigger_out_tb.sv
`timescale 1ns/1ps
module tmr_sync_trigger_out_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       evt_cnt_reset = 1'b0;
  logic       evt_cnt_start = 1'b0;
  logic       evt_update = 1'b0;
  logic       evt_ch0_cc = 1'b0;
  logic       cmp_ref0 = 1'b0;
  logic       cmp_ref1 = 1'b0;
  logic       trgo;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    exp_trgo = 1'b0;
  bit    m_p0 = 1'b0;
  bit    m_p1 = 1'b0;
  string exp_tag = "R10";
  string force_tag = "";
  bit    finished = 1'b0;

  always #4 clk = ~clk;

  tmr_sync_trigger_out u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .evt_cnt_reset(evt_cnt_reset), .evt_cnt_start(evt_cnt_start),
    .evt_update(evt_update), .evt_ch0_cc(evt_ch0_cc),
    .cmp_ref0(cmp_ref0), .cmp_ref1(cmp_ref1), .trgo(trgo)
  );

  // Behavioural reference model, evaluated at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_trgo = 1'b0; m_p0 = 1'b0; m_p1 = 1'b0; exp_tag = "R10";
    end else begin
      case (sel)
        3'd0: begin exp_trgo = evt_cnt_reset; exp_tag = "R1"; end
        3'd1: begin exp_trgo = evt_cnt_start; exp_tag = "R2"; end
        3'd2: begin exp_trgo = evt_update;    exp_tag = "R3"; end
        3'd3: begin exp_trgo = evt_ch0_cc;    exp_tag = "R4"; end
        3'd4: begin exp_trgo = cmp_ref0 && !m_p0; exp_tag = "R5"; end
        3'd5: begin exp_trgo = cmp_ref1 && !m_p1; exp_tag = "R6"; end
        default: begin exp_trgo = 1'b0; exp_tag = "R7"; end
      endcase
      if (!exp_trgo && exp_tag != "R7") exp_tag = {exp_tag, "/R8"};
      m_p0 = cmp_ref0; m_p1 = cmp_ref1;
    end
    if (force_tag != "") exp_tag = force_tag;
  end

  task automatic check_now();
    n_checks++;
    if (trgo !== exp_trgo) begin
      n_errors++;
      $display("FAIL %s: trgo actual=%0b expected=%0b at %0t", exp_tag, trgo, exp_trgo, $time);
    end
  endtask

  task automatic step(input logic [2:0] s, input logic [5:0] ev);
    @(negedge clk);
    check_now();
    sel = s;
    {cmp_ref1, cmp_ref0, evt_ch0_cc, evt_update, evt_cnt_start, evt_cnt_reset} = ev;
  endtask

  task automatic idle(input logic [2:0] s, input int n);
    for (int i = 0; i < n; i++) step(s, {cmp_ref1, cmp_ref0, 4'b0000});
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    repeat (3) step(3'd0, 6'b000000);
    @(negedge clk); check_now(); rst_n = 1'b1;                // R10 reset state
    // R1..R4 strobe modes, with all other strobes busy (R8)
    for (int m = 0; m < 4; m++) begin
      step(3'(m), 6'(1 << m));
      idle(3'(m), 2);
      step(3'(m), 6'b001111 & ~6'(1 << m));                  // R8 unselected ignored
      idle(3'(m), 1);
      step(3'(m), 6'(1 << m)); step(3'(m), 6'(1 << m));       // back to back
      idle(3'(m), 2);
    end
    // R5: held high level pulses once
    step(3'd4, 6'b011111); idle(3'd4, 5);
    step(3'd4, 6'b000000); step(3'd4, 6'b010000); step(3'd4, 6'b000000);
    // R6: ref1 rise, ref0 rise ignored
    step(3'd5, 6'b010000); step(3'd5, 6'b100000); idle(3'd5, 4);
    step(3'd5, 6'b000000); idle(3'd5, 2);
    // R7: reserved codes silent
    for (int m = 6; m < 8; m++) begin
      step(3'(m), 6'b001111); step(3'(m), 6'b110000); step(3'(m), 6'b000000);
      step(3'(m), 6'b111111); idle(3'(m), 2);
    end
    // R9: switch onto references already high gives no pulse
    force_tag = "R9";
    step(3'd0, 6'b110000); idle(3'd0, 2);
    idle(3'd4, 3); idle(3'd5, 3);
    step(3'd5, 6'b000000); step(3'd0, 6'b100000); step(3'd5, 6'b100000);
    idle(3'd5, 2);
    // R10: reference held through reset counts as a rise after release
    force_tag = "R10";
    step(3'd4, 6'b010000);
    @(negedge clk); check_now(); rst_n = 1'b0;
    idle(3'd4, 3);
    @(negedge clk); check_now(); rst_n = 1'b1;
    idle(3'd4, 3);
    force_tag = "";
    // Random traffic across all codes
    for (int i = 0; i < 4000; i++) begin
      step((i % 37 == 0 || $urandom_range(0, 7) == 0) ? 3'($urandom_range(0, 7)) : sel,
           6'($urandom_range(0, 63)));
    end
    idle(3'd0, 3);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule